// File: doc/BRIEF.md
# Display panel power-state sequencer

This block steps an LCD panel controller through its four power states: deep standby, sleep, full-resolution normal and quarter-resolution normal. A host puts a target state on `req_state` and pulses `req_valid` while the block is idle. The block works out the path from the state it holds to the target and plays out the ordered command and data writes for every leg of that path. Each write goes to a serial command engine through a single-outstanding write port. Millisecond pauses are inserted where the panel needs them. When the path ends, or when a write fails, the block pulses `done`, with `err` telling which outcome it was.

Some moves have no direct path. From deep standby, either normal state is reached by way of sleep. Either normal state reaches deep standby by way of sleep. A swap between the two normal states runs four legs: it drops to sleep, powers off to deep standby, wakes to sleep again and then enters the other normal state. The held state, `cur_state`, changes only when every write on the path has been acknowledged.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset `cur_state` is 0, and `busy`, `done` and `wr_valid` are low. The state codes are 0 deep standby, 1 sleep, 2 full-resolution normal and 3 quarter-resolution normal.
- R2: The deep-standby-to-sleep leg sends three bare commands 0x00 (`wr_len`=0). Each one is followed by a pause of at least CLK_HZ/1000 clocks before the next write. The leg then writes 0x17 to register 0xB0 (`wr_len`=1, byte in `wr_data[7:0]`).
- R3: The sleep-to-full-resolution leg writes 0x80 to 0xBC, 0x00 to 0x3B, 0x16 to 0xB0 and 0xFFF9 to 0xB8 (`wr_len`=2, 16-bit value in `wr_data`). It then sends the bare command 0x11 and the panel initialisation list. The leg ends with the full-resolution timing group, whose last write is 0x0E to 0xD5. The whole leg is 38 writes.
- R4: The sleep-to-quarter-resolution leg has the same length and order as the leg in R3. The differences are that 0xBC gets 0x81, 0x3B gets 0x22, and the quarter-resolution timing group replaces the full-resolution one, ending with 0x0A to 0xE0.
- R5: The leg from either normal state to sleep sends the bare command 0x28, then writes 0x8002 to 0xB8, then sends the bare command 0x10.
- R6: The sleep-to-deep-standby leg is a single write of 0x00 to 0xB0.
- R7: Routing is as follows. Deep standby to normal runs R2 then R3 or R4. Normal to deep standby runs R5 then R6. A swap between the normal states runs R5, R6, R2 and then R3 or R4. `cur_state` changes only in the cycle `done` is high with `err` low.
- R8: A request for the state already held gives `done` within two clocks, issues no write, and leaves `cur_state` as it was.
- R9: A write answered with `wr_err` ends the transition at once. `done` and `err` rise together, `cur_state` keeps its old value and no further write is issued.
- R10: A write stays on the port with stable `wr_cmd`, `wr_len` and `wr_data` until `wr_done` or `wr_err`. `wr_valid` is then low for at least one clock before the next write.
- R11: `req_valid` is ignored while `busy` is high, and `done` is high for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start strobe for a transition, taken only when idle |
| req_state | input | 2 | Target state code |
| busy | output | 1 | A transition is in progress |
| done | output | 1 | One-clock pulse at the end of a transition |
| err | output | 1 | Outcome flag, meaningful with `done` (1 = a write failed) |
| cur_state | output | 2 | Committed panel state |
| wr_valid | output | 1 | A write is presented to the serial engine |
| wr_cmd | output | 8 | Command or register byte of the write |
| wr_len | output | 2 | Number of data bytes: 0, 1 or 2 |
| wr_data | output | 16 | Data; one byte in [7:0], or a 16-bit value sent high byte first |
| wr_done | input | 1 | Engine finished the presented write |
| wr_err | input | 1 | Engine failed the presented write |

## Verification
A wrong internal leg pointer or virtual state shows up at the write port as a wrong command, byte or length. It appears on the first write of the leg that follows, which is within a few clocks of the previous acknowledge. A missing leg in a multi-leg path instead changes the total write count and the first or last write of the request. Both are compared for every transition in the table. An error that fails to stop the sequencer is seen as extra writes after `wr_err`. A commit made on the wrong condition is seen as a `cur_state` change in a cycle without a clean `done`.

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_state,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [1:0]  cur_state,
  output logic        wr_valid,
  output logic [7:0]  wr_cmd,
  output logic [1:0]  wr_len,
  output logic [15:0] wr_data,
  input  logic        wr_done,
  input  logic        wr_err
);

  localparam int WAIT_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int WW = $clog2(WAIT_CYC + 1);

  localparam logic [1:0] ST_OFF = 2'd0, ST_SLP = 2'd1, ST_FULL = 2'd2, ST_QTR = 2'd3;
  localparam logic [1:0] LEG_UP = 2'd0, LEG_DOWN = 2'd1, LEG_PWROFF = 2'd2, LEG_WAKE = 2'd3;
  localparam logic [5:0] AT_UP = 6'd0, AT_DOWN = 6'd4, AT_PWROFF = 6'd7, AT_WAKE = 6'd8;

  typedef enum logic [2:0] {PH_IDLE, PH_PLAN, PH_ISSUE, PH_PAUSE, PH_STEP} ph_t;

  function automatic logic [27:0] mk(input logic wt, input logic lst, input logic [1:0] ln,
                                     input logic [7:0] c, input logic [15:0] d);
    return {wt, lst, ln, c, d};
  endfunction

  // {pause_after, last_of_leg, len, cmd, data}
  function automatic logic [27:0] step_word(input logic [5:0] i, input logic q);
    logic [27:0] w;
    case (i)
      6'd0:  w = mk(1'b1, 1'b0, 2'd0, 8'h00, 16'h0000);
      6'd1:  w = mk(1'b1, 1'b0, 2'd0, 8'h00, 16'h0000);
      6'd2:  w = mk(1'b1, 1'b0, 2'd0, 8'h00, 16'h0000);
      6'd3:  w = mk(1'b0, 1'b1, 2'd1, 8'hB0, 16'h0017);
      6'd4:  w = mk(1'b0, 1'b0, 2'd0, 8'h28, 16'h0000);
      6'd5:  w = mk(1'b0, 1'b0, 2'd2, 8'hB8, 16'h8002);
      6'd6:  w = mk(1'b0, 1'b1, 2'd0, 8'h10, 16'h0000);
      6'd7:  w = mk(1'b0, 1'b1, 2'd1, 8'hB0, 16'h0000);
      6'd8:  w = mk(1'b0, 1'b0, 2'd1, 8'hBC, q ? 16'h0081 : 16'h0080);
      6'd9:  w = mk(1'b0, 1'b0, 2'd1, 8'h3B, q ? 16'h0022 : 16'h0000);
      6'd10: w = mk(1'b0, 1'b0, 2'd1, 8'hB0, 16'h0016);
      6'd11: w = mk(1'b0, 1'b0, 2'd2, 8'hB8, 16'hFFF9);
      6'd12: w = mk(1'b0, 1'b0, 2'd0, 8'h11, 16'h0000);
      6'd13: w = mk(1'b0, 1'b0, 2'd1, 8'hBA, 16'h0001);
      6'd14: w = mk(1'b0, 1'b0, 2'd1, 8'hBB, 16'h0000);
      6'd15: w = mk(1'b0, 1'b0, 2'd1, 8'h3A, 16'h0060);
      6'd16: w = mk(1'b0, 1'b0, 2'd1, 8'hBF, 16'h0010);
      6'd17: w = mk(1'b0, 1'b0, 2'd1, 8'hB1, 16'h0056);
      6'd18: w = mk(1'b0, 1'b0, 2'd1, 8'hB2, 16'h0033);
      6'd19: w = mk(1'b0, 1'b0, 2'd1, 8'hB3, 16'h0011);
      6'd20: w = mk(1'b0, 1'b0, 2'd1, 8'hB4, 16'h0002);
      6'd21: w = mk(1'b0, 1'b0, 2'd1, 8'hB5, 16'h002B);
      6'd22: w = mk(1'b0, 1'b0, 2'd1, 8'hB6, 16'h0040);
      6'd23: w = mk(1'b0, 1'b0, 2'd1, 8'hB7, 16'h0003);
      6'd24: w = mk(1'b0, 1'b0, 2'd1, 8'hB9, 16'h0004);
      6'd25: w = mk(1'b0, 1'b0, 2'd1, 8'hBD, 16'h0004);
      6'd26: w = mk(1'b0, 1'b0, 2'd1, 8'hBE, 16'h0000);
      6'd27: w = mk(1'b0, 1'b0, 2'd1, 8'hC0, 16'h0011);
      6'd28: w = mk(1'b0, 1'b0, 2'd1, 8'hC1, 16'h0011);
      6'd29: w = mk(1'b0, 1'b0, 2'd1, 8'hC2, 16'h0011);
      6'd30: w = mk(1'b0, 1'b0, 2'd2, 8'hC3, 16'h2040);
      6'd31: w = mk(1'b0, 1'b0, 2'd2, 8'hC4, 16'h60C0);
      6'd32: w = mk(1'b0, 1'b0, 2'd2, 8'hC5, 16'h1020);
      6'd33: w = mk(1'b0, 1'b0, 2'd2, 8'hC6, 16'h60C0);
      6'd34: w = mk(1'b0, 1'b0, 2'd2, 8'hC7, 16'h5533);
      6'd35: w = mk(1'b0, 1'b0, 2'd1, 8'hC8, 16'h0000);
      6'd36: w = mk(1'b0, 1'b0, 2'd1, 8'hC9, 16'h0000);
      6'd37: w = mk(1'b0, 1'b0, 2'd1, 8'hCA, 16'h0000);
      6'd38: w = q ? mk(1'b0, 1'b0, 2'd2, 8'hED, 16'h00FF) : mk(1'b0, 1'b0, 2'd2, 8'hEC, 16'h01F0);
      6'd39: w = q ? mk(1'b0, 1'b0, 2'd1, 8'hD6, 16'h0002) : mk(1'b0, 1'b0, 2'd1, 8'hCF, 16'h0002);
      6'd40: w = q ? mk(1'b0, 1'b0, 2'd2, 8'hD7, 16'h0804) : mk(1'b0, 1'b0, 2'd2, 8'hD0, 16'h0804);
      6'd41: w = q ? mk(1'b0, 1'b0, 2'd1, 8'hD8, 16'h0001) : mk(1'b0, 1'b0, 2'd1, 8'hD1, 16'h0001);
      6'd42: w = q ? mk(1'b0, 1'b0, 2'd2, 8'hD9, 16'h0008) : mk(1'b0, 1'b0, 2'd2, 8'hD2, 16'h0000);
      6'd43: w = q ? mk(1'b0, 1'b0, 2'd2, 8'hDE, 16'h050A) : mk(1'b0, 1'b0, 2'd2, 8'hD3, 16'h0D0E);
      6'd44: w = q ? mk(1'b0, 1'b0, 2'd2, 8'hDF, 16'h0A19) : mk(1'b0, 1'b0, 2'd2, 8'hD4, 16'h11A4);
      6'd45: w = q ? mk(1'b0, 1'b1, 2'd1, 8'hE0, 16'h000A) : mk(1'b0, 1'b1, 2'd1, 8'hD5, 16'h000E);
      default: w = '0;
    endcase
    return w;
  endfunction

  ph_t         ph;
  logic [5:0]  idx;
  logic [1:0]  leg, vst, tgt, cur_q;
  logic        via_off, done_q, err_q;
  logic [WW-1:0] wcnt;
  logic [27:0] ent;

  assign ent       = step_word(idx, tgt == ST_QTR);
  assign wr_valid  = (ph == PH_ISSUE);
  assign wr_len    = ent[25:24];
  assign wr_cmd    = ent[23:16];
  assign wr_data   = ent[15:0];
  assign busy      = (ph != PH_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign cur_state = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; idx <= '0; leg <= LEG_UP; vst <= ST_OFF; tgt <= ST_OFF;
      cur_q <= ST_OFF; via_off <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; wcnt <= '0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        PH_IDLE: if (req_valid) begin
          tgt     <= req_state;
          vst     <= cur_q;
          via_off <= cur_q[1] & req_state[1] & (cur_q != req_state);
          ph      <= PH_PLAN;
        end
        PH_PLAN: begin
          if (vst == tgt) begin
            done_q <= 1'b1; err_q <= 1'b0; cur_q <= tgt; ph <= PH_IDLE;
          end else begin
            ph <= PH_ISSUE;
            case (vst)
              ST_OFF: begin leg <= LEG_UP; idx <= AT_UP; end
              ST_SLP: if (tgt == ST_OFF || via_off) begin
                leg <= LEG_PWROFF; idx <= AT_PWROFF; via_off <= 1'b0;
              end else begin
                leg <= LEG_WAKE; idx <= AT_WAKE;
              end
              default: begin leg <= LEG_DOWN; idx <= AT_DOWN; end
            endcase
          end
        end
        PH_ISSUE: begin
          if (wr_err) begin
            done_q <= 1'b1; err_q <= 1'b1; ph <= PH_IDLE;
          end else if (wr_done) begin
            wcnt <= '0;
            ph   <= ent[27] ? PH_PAUSE : PH_STEP;
          end
        end
        PH_PAUSE: begin
          if (wcnt == WW'(WAIT_CYC - 1)) ph <= PH_STEP;
          else wcnt <= wcnt + 1'b1;
        end
        PH_STEP: begin
          if (ent[26]) begin
            case (leg)
              LEG_UP, LEG_DOWN: vst <= ST_SLP;
              LEG_PWROFF:       vst <= ST_OFF;
              default:          vst <= tgt;
            endcase
            ph <= PH_PLAN;
          end else begin
            idx <= idx + 1'b1;
            ph  <= PH_ISSUE;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/panel_pwr_seq_chk.sv
module panel_pwr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [1:0]  cur_state,
  input logic        wr_valid,
  input logic [7:0]  wr_cmd,
  input logic [1:0]  wr_len,
  input logic [15:0] wr_data,
  input logic        wr_done,
  input logic        wr_err
);

  p_hold_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_done && !wr_err) |=> (wr_valid && $stable(wr_cmd) && $stable(wr_len) && $stable(wr_data)));

  p_gap_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_done || wr_err)) |=> !wr_valid);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

  p_commit_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_state) |-> (done && !err));

  p_err_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $stable(cur_state));

  p_err_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_err) |=> !busy);

endmodule

bind panel_pwr_seq panel_pwr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err), .cur_state(cur_state),
  .wr_valid(wr_valid), .wr_cmd(wr_cmd), .wr_len(wr_len), .wr_data(wr_data),
  .wr_done(wr_done), .wr_err(wr_err)
);

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_HZ = 200_000;
  localparam int WAIT_CYC = TB_HZ / 1000;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [1:0] req_state = 2'd0;
  logic busy, done, err, wr_valid;
  logic [1:0] cur_state, wr_len;
  logic [7:0] wr_cmd;
  logic [15:0] wr_data;
  logic eng_done = 1'b0, eng_err = 1'b0;

  panel_pwr_seq #(.CLK_HZ(TB_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
    .busy(busy), .done(done), .err(err), .cur_state(cur_state),
    .wr_valid(wr_valid), .wr_cmd(wr_cmd), .wr_len(wr_len), .wr_data(wr_data),
    .wr_done(eng_done), .wr_err(eng_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, nwr = 0, ecnt = 0, err_at = 999;
  logic [7:0]  lg_cmd [64];
  logic [1:0]  lg_len [64];
  logic [15:0] lg_dat [64];
  int          lg_st  [64];

  always @(posedge clk) begin
    cyc = cyc + 1;
    eng_done <= 1'b0;
    eng_err  <= 1'b0;
    if (!rst_n) ecnt = 0;
    else if (wr_valid && !eng_done && !eng_err) begin
      if (ecnt == 0 && nwr < 64) lg_st[nwr] = cyc;
      if (ecnt == 2) begin
        ecnt = 0;
        if (nwr < 64) begin lg_cmd[nwr] = wr_cmd; lg_len[nwr] = wr_len; lg_dat[nwr] = wr_data; end
        if (nwr == err_at) eng_err <= 1'b1; else eng_done <= 1'b1;
        nwr = nwr + 1;
      end else ecnt = ecnt + 1;
    end
  end

  int checks = 0, fails = 0, lat = 0;
  logic got_err;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] t);
    nwr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_state = t;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 3000) begin @(negedge clk); lat++; end
    got_err = err;
    if (lat >= 3000) chk(1'b0, "request timeout", lat, 0);
  endtask

  // target, count, first cmd, first data, last cmd, last data
  localparam logic [57:0] VEC [0:12] = '{
    {2'd0, 8'd0,  8'h00, 16'h0000, 8'h00, 16'h0000},
    {2'd1, 8'd4,  8'h00, 16'h0000, 8'hB0, 16'h0017},
    {2'd2, 8'd38, 8'hBC, 16'h0080, 8'hD5, 16'h000E},
    {2'd3, 8'd46, 8'h28, 16'h0000, 8'hE0, 16'h000A},
    {2'd2, 8'd46, 8'h28, 16'h0000, 8'hD5, 16'h000E},
    {2'd1, 8'd3,  8'h28, 16'h0000, 8'h10, 16'h0000},
    {2'd3, 8'd38, 8'hBC, 16'h0081, 8'hE0, 16'h000A},
    {2'd0, 8'd4,  8'h28, 16'h0000, 8'hB0, 16'h0000},
    {2'd3, 8'd42, 8'h00, 16'h0000, 8'hE0, 16'h000A},
    {2'd3, 8'd0,  8'h00, 16'h0000, 8'h00, 16'h0000},
    {2'd1, 8'd3,  8'h28, 16'h0000, 8'h10, 16'h0000},
    {2'd0, 8'd1,  8'hB0, 16'h0000, 8'hB0, 16'h0000},
    {2'd2, 8'd42, 8'h00, 16'h0000, 8'hD5, 16'h000E}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 9:  return "R8 same state";
      1:     return "R2 standby to sleep";
      2:     return "R3 sleep to full";
      6:     return "R4 sleep to quarter";
      5, 10: return "R5 normal to sleep";
      11:    return "R6 sleep to standby";
      default: return "R7 routed path";
    endcase
  endfunction

  initial begin
    int wd = 0;
    forever begin
      @(negedge clk);
      wd++;
      if (wd > 150000) begin
        chk(1'b0, "watchdog", wd, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cur_state == 2'd0 && !busy && !done && !wr_valid, "R1 reset state",
        {cur_state, busy, done, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_state == 2'd0 && !busy && !wr_valid, "R1 after release", {cur_state, busy, wr_valid}, 0);

    for (int i = 0; i < 13; i++) begin
      logic [1:0] t; int n; logic [7:0] fc, lc; logic [15:0] fd, ld;
      {t, n, fc, fd, lc, ld} = {VEC[i][57:56], 24'd0, VEC[i][55:48], VEC[i][47:40],
                               VEC[i][39:24], VEC[i][23:16], VEC[i][15:0]};
      do_req(t);
      chk(nwr == n, tag_of(i), nwr, n);
      chk(cur_state == t && !got_err, tag_of(i), {got_err, cur_state}, t);
      if (n > 0) begin
        chk(lg_cmd[0] == fc && lg_dat[0] == fd, tag_of(i), {lg_cmd[0], lg_dat[0]}, {fc, fd});
        chk(lg_cmd[n-1] == lc && lg_dat[n-1] == ld, tag_of(i), {lg_cmd[n-1], lg_dat[n-1]}, {lc, ld});
      end else begin
        chk(lat <= 2, "R8 latency", lat, 2);
      end
      if (i == 1)
        for (int k = 0; k < 3; k++)
          chk(lg_cmd[k] == 8'h00 && lg_len[k] == 2'd0 && (lg_st[k+1] - lg_st[k]) >= WAIT_CYC,
              "R2 pause after bare 0x00", lg_st[k+1] - lg_st[k], WAIT_CYC);
      if (i == 2)
        chk(lg_cmd[3] == 8'hB8 && lg_len[3] == 2'd2 && lg_dat[3] == 16'hFFF9 && lg_cmd[4] == 8'h11,
            "R3 output control word", {lg_cmd[3], lg_dat[3]}, {8'hB8, 16'hFFF9});
      if (i == 6)
        chk(lg_cmd[1] == 8'h3B && lg_dat[1] == 16'h0022, "R4 rate byte", {lg_cmd[1], lg_dat[1]}, {8'h3B, 16'h0022});
      if (i == 3)
        chk(lg_cmd[1] == 8'hB8 && lg_dat[1] == 16'h8002 && lg_cmd[3] == 8'hB0 && lg_dat[3] == 16'h0000
            && lg_cmd[4] == 8'h00 && lg_cmd[7] == 8'hB0 && lg_dat[7] == 16'h0017,
            "R7 swap legs", {lg_cmd[3], lg_cmd[7]}, {8'hB0, 8'hB0});
    end

    // back to standby, then a failing wake
    do_req(2'd0);
    chk(cur_state == 2'd0 && nwr == 4, "R7 normal to standby", {cur_state, nwr}, 4);
    err_at = 10;
    do_req(2'd2);
    chk(got_err == 1'b1, "R9 err flag", got_err, 1);
    chk(cur_state == 2'd0, "R9 state kept", cur_state, 0);
    chk(nwr == 11, "R9 write count", nwr, 11);
    repeat (20) @(negedge clk);
    chk(nwr == 11 && !wr_valid && !busy, "R9 no writes after error", nwr, 11);
    err_at = 999;

    // R11 request during busy is ignored
    nwr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_state = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_state = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 3000) begin @(negedge clk); lat++; end
    got_err = err;
    @(negedge clk);
    chk(!done, "R11 done single cycle", done, 0);
    chk(cur_state == 2'd2 && !got_err, "R11 busy request ignored", cur_state, 2);
    chk(nwr == 42, "R11 write count", nwr, 42);
    repeat (10) @(negedge clk);
    chk(!busy && !wr_valid && cur_state == 2'd2, "R11 stays idle", {busy, wr_valid}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule